// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Port

This block is a full-duplex asynchronous serial port controlled through a byte-wide register port. Software picks one of three framed formats with a two-bit mode field: an 8-bit frame at a variable rate, a 9-bit frame at a fixed rate derived from the system clock, or a 9-bit frame at a variable rate. In the variable-rate formats the bit timing comes from an external tick that pulses at 16 times the bit rate. In the fixed-rate format an internal prescaler produces that tick, and a rate-double input selects clock/16 instead of clock/32. Mode 00 is a synchronous shift format that is not built here, so it leaves both directions inactive.

The receiver oversamples the line 16 times per bit. It restarts its phase count on every detected falling start edge and decides each bit by a majority vote of three samples near the middle of the bit. When a frame completes, the block raises a receive-done flag. In the 9-bit formats an address-filter enable holds that flag back when the received ninth bit is 0. In the 8-bit format the same enable holds it back when the stop bit is invalid. An invalid stop bit also sets a sticky framing-error flag. That flag can be read in place of the upper mode bit while the error-view input is high.

Top module: `async_serial_port`

## Requirements
- R1: The control byte sits at address 0 and has this layout: bit7 upper mode bit (framing error when viewed), bit6 lower mode bit, bit5 filter enable, bit4 receive enable, bit3 transmit ninth bit, bit2 received ninth bit, bit1 transmit-done, bit0 receive-done. Address 1 takes the transmit byte on a write and returns the received byte on a read. After reset every register reads 0 and txd is 1. In mode 00 a data write sends nothing and txd stays 1.
- R2: A data write while the transmitter is idle starts a frame. The frame is a low start bit, then 8 data bits LSB first, then an optional ninth bit, then a high stop bit. Each bit lasts 16 ticks.
- R3: In modes 10 and 11 the transmitted ninth bit equals control bit3.
- R4: Transmit-done (bit1) is set when the stop bit begins. A data write while a frame is in progress is ignored.
- R5: A receive frame starts at a falling edge on rxd. Each bit is taken as the majority of samples 7, 8 and 9 of its 16. A start bit that votes high is treated as a false start and no frame results. A single-sample glitch does not change a bit.
- R6: Receive-done (bit0) is set in the middle of the stop bit. In modes 10 and 11, bit2 stores the received ninth bit. In mode 01, bit2 stores the received stop bit.
- R7: In modes 10 and 11 with the filter enable set, a frame whose ninth bit is 0 does not set receive-done and does not update the received byte.
- R8: In mode 01 with the filter enable set, a frame with a low stop bit does not set receive-done.
- R9: A low stop bit sets the framing-error flag. Later valid frames do not clear it. While the view input is high, bit7 reads the flag, and a control write with bit7 = 0 clears it while leaving the mode unchanged. While the view input is low, bit7 reads the upper mode bit.
- R10: While receive enable (bit4) is 0, no frame is received.
- R11: A frame that completes while receive-done is still set is discarded, and the received byte keeps its old value.
- R12: In mode 10 one bit lasts 32 clocks when rate_double is 0 and 16 clocks when it is 1.
- R13: The transmit-done and receive-done flags stay set until a control write clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 transmit byte |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read select: 0 control, 1 received byte |
| rd_data | output | 8 | Read data (combinational) |
| fe_view | input | 1 | Selects the framing-error view of control bit7 |
| rate_double | input | 1 | Mode 10 rate select: 1 clock/16, 0 clock/32 |
| baud_tick16 | input | 1 | 16x bit-rate tick for modes 01 and 11 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_done_irq | output | 1 | Transmit-done flag |
| rx_done_irq | output | 1 | Receive-done flag |

## Verification
The assertions assume that rxd may change at any time but is sampled only through the synchronizer. They also assume that the mode field is not rewritten while a frame is in flight, and that baud_tick16 is a single-cycle strobe. The bench changes the mode only between frames. It drives rxd on falling clock edges, holding each bit for the exact bit period of the selected rate. The external tick is held high, which makes every clock a tick and keeps the 16-clock bit period of the fast fixed rate.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int OVS = 16;

  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'b00,
    MODE_A8     = 2'b01,
    MODE_A9_FIX = 2'b10,
    MODE_A9_VAR = 2'b11
  } sport_mode_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/sport_tick_sel.sv
module sport_tick_sel
  import sport_pkg::*;
#(
  parameter int SLOW_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  sport_mode_e mode,
  input  logic        rate_double,
  input  logic        ext_tick,
  output logic        tick
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] div_q, div_d;
  logic          fixed_rate;

  assign fixed_rate = (mode == MODE_A9_FIX);

  always_comb begin
    if (!fixed_rate || rate_double) div_d = '0;
    else if (div_q == LAST)         div_d = '0;
    else                            div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  always_comb begin
    if (fixed_rate) tick = rate_double | (div_q == LAST);
    else            tick = (mode != MODE_SHIFT) & ext_tick;
  end

  // R12
  slow_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_rate && !rate_double && tick && SLOW_DIV > 1) |=> !tick);
endmodule

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          nine,
  input  logic          bit9,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy,
  output logic          stop_begin
);
  localparam int FW = DW + 3;
  localparam int IW = $clog2(FW + 1);
  localparam logic [3:0] PH_LAST = 4'(OVS - 1);
  localparam logic [IW-1:0] LAST8 = IW'(DW + 1);
  localparam logic [IW-1:0] LAST9 = IW'(DW + 2);

  logic          busy_q, busy_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [IW-1:0] idx_q, idx_d, last_q, last_d;
  logic [3:0]    ph_q, ph_d;

  always_comb begin
    busy_d     = busy_q;
    sh_d       = sh_q;
    idx_d      = idx_q;
    last_d     = last_q;
    ph_d       = ph_q;
    stop_begin = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
        last_d = nine ? LAST9 : LAST8;
        idx_d  = '0;
        ph_d   = '0;
      end
    end else if (tick) begin
      ph_d = ph_q + 1'b1;
      if (ph_q == PH_LAST) begin
        if (idx_q == last_q) begin
          busy_d = 1'b0;
        end else begin
          sh_d  = {1'b1, sh_q[FW-1:1]};
          idx_d = idx_q + 1'b1;
          if (idx_q + 1'b1 == last_q) stop_begin = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      last_q <= '0;
      ph_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      ph_q   <= ph_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;

  // R2
  tx_hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(txd));
  // R4
  tx_ignore_busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !tick) |=> $stable(sh_q));
endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          active,
  input  logic          nine,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          stop_bit
);
  localparam int IW = $clog2(DW + 3);
  localparam logic [IW-1:0] LAST8 = IW'(DW + 1);
  localparam logic [IW-1:0] LAST9 = IW'(DW + 2);
  localparam logic [IW-1:0] NINTH = IW'(DW + 1);
  localparam logic [IW-1:0] DLAST = IW'(DW);
  localparam logic [3:0] PH_S7 = 4'd6;
  localparam logic [3:0] PH_S8 = 4'd7;
  localparam logic [3:0] PH_S9 = 4'd8;
  localparam logic [3:0] PH_LAST = 4'(OVS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rxd;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      end
    end
  endgenerate
  assign rx_s = sync_q[SYNC_STAGES-1];

  rx_state_e     st_q, st_d;
  logic [3:0]    ph_q, ph_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          s7_q, s7_d, s8_q, s8_d, prev_q, prev_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          b9_q, b9_d, stop_q, stop_d, done_q, done_d;
  logic [IW-1:0] last_idx;
  logic          vote;

  assign last_idx = nine ? LAST9 : LAST8;
  assign vote     = (s7_q & s8_q) | (s7_q & rx_s) | (s8_q & rx_s);

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    s7_d   = s7_q;
    s8_d   = s8_q;
    sh_d   = sh_q;
    b9_d   = b9_q;
    stop_d = stop_q;
    done_d = 1'b0;
    prev_d = tick ? rx_s : prev_q;
    if (!active) begin
      st_d = RX_IDLE;
    end else if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (prev_q && !rx_s) begin
            st_d  = RX_RUN;
            ph_d  = '0;
            idx_d = '0;
          end
        end
        RX_RUN: begin
          ph_d = ph_q + 1'b1;
          if (ph_q == PH_S7) s7_d = rx_s;
          if (ph_q == PH_S8) s8_d = rx_s;
          if (ph_q == PH_S9) begin
            if (idx_q == '0) begin
              if (vote) st_d = RX_IDLE;
            end else if (idx_q <= DLAST) begin
              sh_d = {vote, sh_q[DW-1:1]};
            end else if (idx_q == last_idx) begin
              stop_d = vote;
              done_d = 1'b1;
              st_d   = RX_IDLE;
            end else if (idx_q == NINTH) begin
              b9_d = vote;
            end
          end
          if (ph_q == PH_LAST) idx_d = idx_q + 1'b1;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      ph_q   <= '0;
      idx_q  <= '0;
      s7_q   <= 1'b1;
      s8_q   <= 1'b1;
      prev_q <= 1'b1;
      sh_q   <= '0;
      b9_q   <= 1'b0;
      stop_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      s7_q   <= s7_d;
      s8_q   <= s8_d;
      prev_q <= prev_d;
      sh_q   <= sh_d;
      b9_q   <= b9_d;
      stop_q <= stop_d;
      done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign data     = sh_q;
  assign bit9     = b9_q;
  assign stop_bit = stop_q;

  // R10
  rx_done_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(active));
  // R5
  rx_start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_IDLE && st_d == RX_RUN) |-> (prev_q && !rx_s));
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import sport_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SLOW_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  input  logic       fe_view,
  input  logic       rate_double,
  input  logic       baud_tick16,
  input  logic       rxd,
  output logic       txd,
  output logic       tx_done_irq,
  output logic       rx_done_irq
);
  logic [1:0]    mode_q, mode_d;
  logic          fe_q, fe_d, filt_q, filt_d, ren_q, ren_d;
  logic          tb9_q, tb9_d, rb9_q, rb9_d, ti_q, ti_d, ri_q, ri_d;
  logic [DW-1:0] rxbuf_q, rxbuf_d;

  sport_mode_e   mode;
  logic          tick, nine, ctrl_wr, data_wr, tx_start;
  logic          tx_busy, tx_stop_begin;
  logic          rx_active, rx_frame_done, rx_b9, rx_stop, rx_pass;
  logic [DW-1:0] rx_byte;

  assign mode      = sport_mode_e'(mode_q);
  assign nine      = mode_q[1];
  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign data_wr   = wr_en && (wr_addr == ADDR_DATA);
  assign tx_start  = data_wr && (mode != MODE_SHIFT);
  assign rx_active = ren_q && (mode != MODE_SHIFT);

  sport_tick_sel #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rate_double(rate_double),
    .ext_tick(baud_tick16), .tick(tick)
  );

  sport_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start), .nine(nine),
    .bit9(tb9_q), .data(wr_data[DW-1:0]), .txd(txd), .busy(tx_busy),
    .stop_begin(tx_stop_begin)
  );

  sport_rx #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(rx_active), .nine(nine),
    .rxd(rxd), .done(rx_frame_done), .data(rx_byte), .bit9(rx_b9),
    .stop_bit(rx_stop)
  );

  always_comb begin
    if (nine) rx_pass = !(filt_q && !rx_b9);
    else      rx_pass = !(filt_q && !rx_stop);
  end

  always_comb begin
    mode_d  = mode_q;
    fe_d    = fe_q;
    filt_d  = filt_q;
    ren_d   = ren_q;
    tb9_d   = tb9_q;
    rb9_d   = rb9_q;
    ti_d    = ti_q;
    ri_d    = ri_q;
    rxbuf_d = rxbuf_q;
    if (ctrl_wr) begin
      if (fe_view) begin
        if (!wr_data[7]) fe_d = 1'b0;
      end else begin
        mode_d[1] = wr_data[7];
      end
      mode_d[0] = wr_data[6];
      filt_d    = wr_data[5];
      ren_d     = wr_data[4];
      tb9_d     = wr_data[3];
      rb9_d     = wr_data[2];
      ti_d      = wr_data[1];
      ri_d      = wr_data[0];
    end
    if (tx_stop_begin) ti_d = 1'b1;
    if (rx_frame_done) begin
      if (!rx_stop) fe_d = 1'b1;
      if (!ri_q && rx_pass) begin
        ri_d    = 1'b1;
        rxbuf_d = rx_byte;
        rb9_d   = nine ? rx_b9 : rx_stop;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      fe_q    <= 1'b0;
      filt_q  <= 1'b0;
      ren_q   <= 1'b0;
      tb9_q   <= 1'b0;
      rb9_q   <= 1'b0;
      ti_q    <= 1'b0;
      ri_q    <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      mode_q  <= mode_d;
      fe_q    <= fe_d;
      filt_q  <= filt_d;
      ren_q   <= ren_d;
      tb9_q   <= tb9_d;
      rb9_q   <= rb9_d;
      ti_q    <= ti_d;
      ri_q    <= ri_d;
      rxbuf_q <= rxbuf_d;
    end
  end

  always_comb begin
    if (rd_addr == ADDR_DATA) begin
      rd_data = 8'(rxbuf_q);
    end else begin
      rd_data = {(fe_view ? fe_q : mode_q[1]), mode_q[0], filt_q, ren_q,
                 tb9_q, rb9_q, ti_q, ri_q};
    end
  end

  assign tx_done_irq = ti_q;
  assign rx_done_irq = ri_q;

  // R9
  fe_clear_only_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fe_q) |-> $past(ctrl_wr && fe_view && !wr_data[7]));
  // R11
  overrun_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_q && rx_frame_done) |=> $stable(rxbuf_q));
  // R13
  ri_clear_only_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ri_q) |-> $past(ctrl_wr));
  // R4
  ti_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti_q) |-> $past(tx_stop_begin || ctrl_wr));
  // R7
  filter_blocks_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_done && nine && filt_q && !rx_b9 && !ctrl_wr) |=> $stable(ri_q));
endmodule

// File: tb/async_serial_port_tb.sv
module async_serial_port_tb;
  logic       clk, rst_n;
  logic       wr_en, wr_addr, rd_addr, fe_view, rate_double, baud_tick16, rxd;
  logic [7:0] wr_data, rd_data;
  logic       txd, tx_done_irq, rx_done_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] last_good;

  async_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .fe_view(fe_view), .rate_double(rate_double), .baud_tick16(baud_tick16),
    .rxd(rxd), .txd(txd), .tx_done_irq(tx_done_irq), .rx_done_irq(rx_done_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: {mode[1:0], filt, ninth, stop, exp_done, exp_rb9, data[7:0]}
  localparam int NV = 8;
  localparam logic [14:0] RX_VEC [0:NV-1] = '{
    {2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA5},
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A},
    {2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hC3},
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81},
    {2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h7E},
    {2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h42},
    {2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF}
  };

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit has9, input logic b9,
                            input logic stp, input int per, input int glitch);
    logic [10:0] bits;
    int n;
    bits = {stp, (has9 ? b9 : stp), d, 1'b0};
    n = has9 ? 11 : 10;
    for (int k = 0; k < n; k++) begin
      logic v;
      v = (!has9 && k == 9) ? stp : bits[k];
      @(negedge clk);
      rxd = v;
      if (k == glitch) begin
        repeat (8) @(negedge clk);
        rxd = ~v;
        @(negedge clk);
        rxd = v;
        repeat (per - 10) @(negedge clk);
      end else begin
        repeat (per - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic tx_check(input logic [7:0] d, input bit has9, input logic b9,
                          input int per, input bit inject);
    int n;
    logic expb;
    wr(1'b1, d);
    n = has9 ? 11 : 10;
    repeat (per / 2 + 1) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k == 0)                expb = 1'b0;
      else if (k <= 8)           expb = d[k-1];
      else if (has9 && k == 9)   expb = b9;
      else                       expb = 1'b1;
      if (has9 && k == 9)
        chk(txd == expb, "R3 ninth bit", 16'(txd), 16'(expb));
      else
        chk(txd == expb, "R2 frame bit", 16'(txd), 16'(expb));
      if (k == n - 2) chk(tx_done_irq == 1'b0, "R4 done before stop", 16'(tx_done_irq), 16'd0);
      if (k == n - 1) chk(tx_done_irq == 1'b1, "R4 done at stop", 16'(tx_done_irq), 16'd1);
      if (inject && k == 2) begin
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (per - 1) @(negedge clk);
      end else begin
        repeat (per) @(negedge clk);
      end
    end
    if (inject) begin
      for (int j = 0; j < 4; j++) begin
        chk(txd == 1'b1, "R4 busy write ignored", 16'(txd), 16'd1);
        repeat (per / 2) @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0;
    fe_view = 1'b0; rate_double = 1'b1; baud_tick16 = 1'b1; rxd = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, r); chk(r == 8'h00, "R1 reset control", 16'(r), 16'h00);
    rd(1'b1, r); chk(r == 8'h00, "R1 reset data", 16'(r), 16'h00);
    chk(txd == 1'b1, "R1 reset txd", 16'(txd), 16'd1);
    chk({tx_done_irq, rx_done_irq} == 2'b00, "R1 reset flags", 16'({tx_done_irq, rx_done_irq}), 16'd0);

    // R1 mode 00 inactive
    wr(1'b1, 8'h00);
    begin
      bit stayed;
      stayed = 1'b1;
      for (int j = 0; j < 40; j++) begin
        @(negedge clk);
        if (txd !== 1'b1) stayed = 1'b0;
      end
      chk(stayed, "R1 mode00 no transmit", 16'(stayed), 16'd1);
    end

    // receive vector table: R6 R7 R8
    last_good = 8'h00;
    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = RX_VEC[i];
      wr(1'b0, {v[14:13], v[12], 1'b1, 4'b0000});
      send_frame(v[7:0], v[14], v[11], v[10], 16, -1);
      rd(1'b0, r);
      chk(r[0] == v[9], "R6 R7 R8 receive-done", 16'(r[0]), 16'(v[9]));
      rd(1'b1, r);
      if (v[9]) begin
        chk(r == v[7:0], "R6 received byte", 16'(r), 16'(v[7:0]));
        rd(1'b0, r);
        chk(r[2] == v[8], "R6 ninth status", 16'(r[2]), 16'(v[8]));
        last_good = v[7:0];
      end else begin
        chk(r == last_good, "R7 R8 filtered byte kept", 16'(r), 16'(last_good));
      end
    end

    // R9 framing error sticky view
    wr(1'b0, 8'h50);
    fe_view = 1'b0;
    rd(1'b0, r); chk(r[7] == 1'b0, "R9 view off mode bit", 16'(r[7]), 16'd0);
    fe_view = 1'b1;
    rd(1'b0, r); chk(r[7] == 1'b1, "R9 sticky error", 16'(r[7]), 16'd1);
    wr(1'b0, 8'h50);
    rd(1'b0, r); chk(r[7] == 1'b0, "R9 error cleared", 16'(r[7]), 16'd0);
    fe_view = 1'b0;
    rd(1'b0, r); chk(r[7:6] == 2'b01, "R9 mode unchanged", 16'(r[7:6]), 16'd1);

    // R5 false start then valid frame
    @(negedge clk); rxd = 1'b0;
    repeat (5) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    rd(1'b0, r); chk(r[0] == 1'b0, "R5 false start", 16'(r[0]), 16'd0);
    send_frame(8'h6B, 1'b0, 1'b0, 1'b1, 16, 3);
    rd(1'b1, r); chk(r == 8'h6B, "R5 glitch rejected", 16'(r), 16'h6B);

    // R11 overrun keeps old byte; R13 flag persists
    send_frame(8'h19, 1'b0, 1'b0, 1'b1, 16, -1);
    rd(1'b1, r); chk(r == 8'h6B, "R11 overrun discarded", 16'(r), 16'h6B);
    repeat (50) @(negedge clk);
    chk(rx_done_irq == 1'b1, "R13 flag held", 16'(rx_done_irq), 16'd1);
    wr(1'b0, 8'h50);
    chk(rx_done_irq == 1'b0, "R13 flag cleared by write", 16'(rx_done_irq), 16'd0);

    // R10 receive disabled
    wr(1'b0, 8'h40);
    send_frame(8'hE7, 1'b0, 1'b0, 1'b1, 16, -1);
    rd(1'b0, r); chk(r[0] == 1'b0, "R10 disabled no done", 16'(r[0]), 16'd0);
    rd(1'b1, r); chk(r == 8'h6B, "R10 byte unchanged", 16'(r), 16'h6B);

    // R2 R4 transmit mode 01 with busy write
    wr(1'b0, 8'h40);
    tx_check(8'h3A, 1'b0, 1'b0, 16, 1'b1);
    // R3 transmit ninth bit, mode 11
    wr(1'b0, 8'hC8);
    tx_check(8'h96, 1'b1, 1'b1, 16, 1'b0);
    wr(1'b0, 8'hC0);
    tx_check(8'h69, 1'b1, 1'b0, 16, 1'b0);
    // R12 mode 10 slow rate
    rate_double = 1'b0;
    wr(1'b0, 8'h88);
    tx_check(8'hC5, 1'b1, 1'b1, 32, 1'b0);
    rate_double = 1'b1;
    wr(1'b0, 8'h80);
    tx_check(8'h2D, 1'b1, 1'b0, 16, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule